// File: doc/BRIEF.md
# Reconfiguration Handshake Controller

This block is the control sequencer that lives inside a swappable compute module and steers the exchange of messages around a partial reconfiguration of that module. It talks to a message engine through four first-word-fall-through FIFOs. On the outbound side there is one FIFO for command words and one for payload words. On the inbound side there is one FIFO for arrival control words and one for payload words. It also holds the module's context, a small array of words that the application reads and writes while the module runs.

When the host sends a configure request, the controller replies with a consent message whose payload is the context. It then posts a receive command for the later completion message and parks. The module can also start the swap itself through a request input. After the successor module comes out of reset, the controller reads an "engine initialized" flag that lives outside the swappable region. If the flag is clear, it issues a one-time engine initialization and asks for the flag to be set. If the flag is set, it waits for the completion message and loads the context from that message's payload.

Top module: `rcfg_handshake_ctrl`

## Requirements
- R1: While `rst_n` is low, every FIFO strobe, `init_flag_set_o`, `app_word_valid_o`, `running_o` and `parked_o` are 0, and every context slot reads 0.
- R2: A command or payload word is written only in a cycle where the matching full input is 0. A FIFO is read only in a cycle where its empty input is 0. The transfer happens at the rising edge where the strobe is high, and data is read from the head of a FIFO in the same cycle as its read strobe.
- R3: With `init_flag_i` clear after reset, the block writes exactly one init command (op 2'b11, rank 0, length 0, tag 0), pulses `init_flag_set_o` in the same cycle, and then raises `running_o`. Command words are {op[29:28], rank[27:20], length[19:8], tag[7:0]}, with op 2'b01 for send and 2'b10 for receive.
- R4: With `init_flag_i` set after reset, no init command is issued. Arrival control words whose tag (bits 7:0) is not the done tag 0xF1 are read and dropped. On a word with the done tag, the block reads CTX_WORDS inbound payload words into context slots 0 to CTX_WORDS-1 in that order, then raises `running_o`.
- R5: Context writes through `ctx_wr_en_i` take effect only while `running_o` is high, and are ignored otherwise. `ctx_rd_data_o` shows slot `ctx_rd_idx_i` combinationally.
- R6: While running, an arrival word with the configure tag 0xF0 makes the block send the command {01, HOST_RANK, CTX_WORDS, 0xF0}, followed by the context slots as payload in ascending order.
- R7: After the last payload word, the block writes the receive command {10, HOST_RANK, CTX_WORDS, 0xF1} and raises `parked_o`. It then touches no FIFO and ignores `pr_request_i` and arrivals until reset.
- R8: While running with the inbound command FIFO empty, a high `pr_request_i` sends {01, HOST_RANK, CTX_WORDS, 0xF1} plus the context payload, then the receive post of R7. A pending arrival word takes precedence over `pr_request_i` in the same cycle.
- R9: While running, an arrival word with any tag other than 0xF0 is read and shown on `app_word_o` with `app_word_valid_o` high for that cycle, and the block stays running.
- R10: When full and empty flags toggle in any pattern, the block stalls without dropping, duplicating or reordering words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the swappable module |
| init_flag_i | input | 1 | External flag: engine already initialized |
| init_flag_set_o | output | 1 | Pulse asking the external flag to be set |
| pr_request_i | input | 1 | Module-initiated swap request |
| cmd_wr_en_o | output | 1 | Outbound command FIFO write strobe |
| cmd_wdata_o | output | 2+RANK_W+LEN_W+TAG_W | Outbound command word |
| cmd_full_i | input | 1 | Outbound command FIFO full |
| dout_wr_en_o | output | 1 | Outbound payload FIFO write strobe |
| dout_wdata_o | output | DATA_W | Outbound payload word |
| dout_full_i | input | 1 | Outbound payload FIFO full |
| cin_rd_en_o | output | 1 | Inbound control FIFO read strobe |
| cin_rdata_i | input | 2+RANK_W+LEN_W+TAG_W | Inbound control word at FIFO head |
| cin_empty_i | input | 1 | Inbound control FIFO empty |
| din_rd_en_o | output | 1 | Inbound payload FIFO read strobe |
| din_rdata_i | input | DATA_W | Inbound payload word at FIFO head |
| din_empty_i | input | 1 | Inbound payload FIFO empty |
| ctx_wr_en_i | input | 1 | Application context write enable |
| ctx_wr_idx_i | input | IDX_W | Context slot to write |
| ctx_wr_data_i | input | DATA_W | Context write data |
| ctx_rd_idx_i | input | IDX_W | Context slot to read |
| ctx_rd_data_o | output | DATA_W | Context read data |
| app_word_valid_o | output | 1 | Non-configuration arrival word handed to the application |
| app_word_o | output | 2+RANK_W+LEN_W+TAG_W | That arrival word |
| running_o | output | 1 | Module is in normal operation |
| parked_o | output | 1 | Handshake done, waiting for reconfiguration |

## Verification
The hardest situation to reach from the ports is a successor module that wakes with the flag already set. This happens only after an earlier run has set the flag and the block has been reset without clearing it. The bench therefore keeps the flag in its own register that survives `rst_n`. It first runs a fresh boot that sets the flag, then resets the block and delivers a stray tag before the done word, with the payload FIFO starved and refilled under a toggling empty pattern. A second corner is the cycle where an arrival and `pr_request_i` coincide. The bench reaches it by making the arrival visible one cycle before it raises the request.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  // Operation field of a command word (two most significant bits)
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SEND = 2'b01,
    OP_RECV = 2'b10,
    OP_INIT = 2'b11
  } rcfg_op_e;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_INIT,
    ST_WAIT_DONE,
    ST_RESTORE,
    ST_RUN,
    ST_ANNOUNCE,
    ST_PAYLOAD,
    ST_POST_RECV,
    ST_PARKED
  } rcfg_state_e;

  // Which command word the formatter presents
  typedef enum logic [1:0] {
    CSEL_INIT,
    CSEL_CONSENT,
    CSEL_REQUEST,
    CSEL_POST
  } rcfg_csel_e;

endpackage

// File: rtl/rcfg_cmd_fmt.sv
module rcfg_cmd_fmt
  import rcfg_pkg::*;
#(
  parameter int RANK_W    = 8,
  parameter int LEN_W     = 12,
  parameter int TAG_W     = 8,
  parameter int HOST_RANK = 0,
  parameter int CTX_WORDS = 4,
  parameter logic [TAG_W-1:0] TAG_CFG  = 8'hF0,
  parameter logic [TAG_W-1:0] TAG_DONE = 8'hF1,
  localparam int CMD_W = 2 + RANK_W + LEN_W + TAG_W
) (
  input  rcfg_csel_e       csel_i,
  output logic [CMD_W-1:0] cmd_o
);

  localparam logic [RANK_W-1:0] HOST_L = RANK_W'(HOST_RANK);
  localparam logic [LEN_W-1:0]  LEN_L  = LEN_W'(CTX_WORDS);

  function automatic logic [CMD_W-1:0] pack_cmd(
    input rcfg_op_e          op,
    input logic [RANK_W-1:0] rank,
    input logic [LEN_W-1:0]  len,
    input logic [TAG_W-1:0]  tag
  );
    return {op, rank, len, tag};
  endfunction

  always_comb begin
    unique case (csel_i)
      CSEL_INIT:    cmd_o = pack_cmd(OP_INIT, '0, '0, '0);
      CSEL_CONSENT: cmd_o = pack_cmd(OP_SEND, HOST_L, LEN_L, TAG_CFG);
      CSEL_REQUEST: cmd_o = pack_cmd(OP_SEND, HOST_L, LEN_L, TAG_DONE);
      CSEL_POST:    cmd_o = pack_cmd(OP_RECV, HOST_L, LEN_L, TAG_DONE);
    endcase
  end

endmodule

// File: rtl/rcfg_ctx_store.sv
module rcfg_ctx_store #(
  parameter int DATA_W    = 32,
  parameter int CTX_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_we_i,
  input  logic [IDX_W-1:0]  app_widx_i,
  input  logic [DATA_W-1:0] app_wdata_i,
  input  logic              rest_we_i,
  input  logic [IDX_W-1:0]  rest_idx_i,
  input  logic [DATA_W-1:0] rest_data_i,
  input  logic [IDX_W-1:0]  app_ridx_i,
  output logic [DATA_W-1:0] app_rdata_o,
  input  logic [IDX_W-1:0]  snd_idx_i,
  output logic [DATA_W-1:0] snd_data_o
);

  logic [DATA_W-1:0] slot_q [CTX_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTX_WORDS; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < CTX_WORDS; i++) begin
        if (rest_we_i && rest_idx_i == IDX_W'(i))
          slot_q[i] <= rest_data_i;
        else if (app_we_i && app_widx_i == IDX_W'(i))
          slot_q[i] <= app_wdata_i;
      end
    end
  end

  assign app_rdata_o = slot_q[app_ridx_i];
  assign snd_data_o  = slot_q[snd_idx_i];

endmodule

// File: rtl/rcfg_hs_fsm.sv
module rcfg_hs_fsm
  import rcfg_pkg::*;
#(
  parameter int TAG_W     = 8,
  parameter int CTX_WORDS = 4,
  parameter int IDX_W     = 2,
  parameter logic [TAG_W-1:0] TAG_CFG  = 8'hF0,
  parameter logic [TAG_W-1:0] TAG_DONE = 8'hF1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_flag_i,
  input  logic             pr_request_i,
  input  logic             cmd_full_i,
  input  logic             dout_full_i,
  input  logic             cin_empty_i,
  input  logic [TAG_W-1:0] cin_tag_i,
  input  logic             din_empty_i,
  output logic             cmd_wr_en_o,
  output rcfg_csel_e       csel_o,
  output logic             dout_wr_en_o,
  output logic             cin_rd_en_o,
  output logic             din_rd_en_o,
  output logic             restore_we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             init_set_o,
  output logic             app_word_valid_o,
  output logic             running_o,
  output logic             parked_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CTX_WORDS - 1);

  rcfg_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             req_q, req_d;

  // Named internal events
  logic idx_last;
  logic cin_is_cfg;
  logic cin_is_done;

  assign idx_last    = (idx_q == IDX_LAST);
  assign cin_is_cfg  = (cin_tag_i == TAG_CFG);
  assign cin_is_done = (cin_tag_i == TAG_DONE);

  always_comb begin
    state_d          = state_q;
    idx_d            = idx_q;
    req_d            = req_q;
    cmd_wr_en_o      = 1'b0;
    csel_o           = CSEL_INIT;
    dout_wr_en_o     = 1'b0;
    cin_rd_en_o      = 1'b0;
    din_rd_en_o      = 1'b0;
    restore_we_o     = 1'b0;
    init_set_o       = 1'b0;
    app_word_valid_o = 1'b0;
    unique case (state_q)
      ST_BOOT: state_d = init_flag_i ? ST_WAIT_DONE : ST_INIT;
      ST_INIT: begin
        csel_o      = CSEL_INIT;
        cmd_wr_en_o = !cmd_full_i;
        init_set_o  = !cmd_full_i;
        if (!cmd_full_i) state_d = ST_RUN;
      end
      ST_WAIT_DONE: begin
        cin_rd_en_o = !cin_empty_i;
        if (!cin_empty_i && cin_is_done) begin
          state_d = ST_RESTORE;
          idx_d   = '0;
        end
      end
      ST_RESTORE: begin
        din_rd_en_o  = !din_empty_i;
        restore_we_o = !din_empty_i;
        if (!din_empty_i) begin
          idx_d = idx_q + IDX_W'(1);
          if (idx_last) state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!cin_empty_i) begin
          cin_rd_en_o = 1'b1;
          if (cin_is_cfg) begin
            state_d = ST_ANNOUNCE;
            req_d   = 1'b0;
          end else begin
            app_word_valid_o = 1'b1;
          end
        end else if (pr_request_i) begin
          state_d = ST_ANNOUNCE;
          req_d   = 1'b1;
        end
      end
      ST_ANNOUNCE: begin
        csel_o      = req_q ? CSEL_REQUEST : CSEL_CONSENT;
        cmd_wr_en_o = !cmd_full_i;
        if (!cmd_full_i) begin
          state_d = ST_PAYLOAD;
          idx_d   = '0;
        end
      end
      ST_PAYLOAD: begin
        dout_wr_en_o = !dout_full_i;
        if (!dout_full_i) begin
          idx_d = idx_q + IDX_W'(1);
          if (idx_last) state_d = ST_POST_RECV;
        end
      end
      ST_POST_RECV: begin
        csel_o      = CSEL_POST;
        cmd_wr_en_o = !cmd_full_i;
        if (!cmd_full_i) state_d = ST_PARKED;
      end
      ST_PARKED: state_d = ST_PARKED;
      default:   state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      idx_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      req_q   <= req_d;
    end
  end

  assign idx_o     = idx_q;
  assign running_o = (state_q == ST_RUN);
  assign parked_o  = (state_q == ST_PARKED);

  // R7: once parked, the block stays parked
  a_r7_parked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    parked_o |=> parked_o);

  // R7: a parked block moves no FIFO
  a_r7_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    parked_o |-> !(cmd_wr_en_o || dout_wr_en_o || cin_rd_en_o || din_rd_en_o));

endmodule

// File: rtl/rcfg_handshake_ctrl.sv
module rcfg_handshake_ctrl
  import rcfg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CTX_WORDS = 4,
  parameter int RANK_W    = 8,
  parameter int LEN_W     = 12,
  parameter int TAG_W     = 8,
  parameter int HOST_RANK = 0,
  parameter logic [TAG_W-1:0] TAG_CFG  = 8'hF0,
  parameter logic [TAG_W-1:0] TAG_DONE = 8'hF1,
  localparam int CMD_W = 2 + RANK_W + LEN_W + TAG_W,
  localparam int IDX_W = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_flag_i,
  output logic              init_flag_set_o,
  input  logic              pr_request_i,
  output logic              cmd_wr_en_o,
  output logic [CMD_W-1:0]  cmd_wdata_o,
  input  logic              cmd_full_i,
  output logic              dout_wr_en_o,
  output logic [DATA_W-1:0] dout_wdata_o,
  input  logic              dout_full_i,
  output logic              cin_rd_en_o,
  input  logic [CMD_W-1:0]  cin_rdata_i,
  input  logic              cin_empty_i,
  output logic              din_rd_en_o,
  input  logic [DATA_W-1:0] din_rdata_i,
  input  logic              din_empty_i,
  input  logic              ctx_wr_en_i,
  input  logic [IDX_W-1:0]  ctx_wr_idx_i,
  input  logic [DATA_W-1:0] ctx_wr_data_i,
  input  logic [IDX_W-1:0]  ctx_rd_idx_i,
  output logic [DATA_W-1:0] ctx_rd_data_o,
  output logic              app_word_valid_o,
  output logic [CMD_W-1:0]  app_word_o,
  output logic              running_o,
  output logic              parked_o
);

  rcfg_csel_e       csel;
  logic [IDX_W-1:0] idx;
  logic             restore_we;
  logic             app_we;

  rcfg_hs_fsm #(
    .TAG_W    (TAG_W),
    .CTX_WORDS(CTX_WORDS),
    .IDX_W    (IDX_W),
    .TAG_CFG  (TAG_CFG),
    .TAG_DONE (TAG_DONE)
  ) i_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .init_flag_i     (init_flag_i),
    .pr_request_i    (pr_request_i),
    .cmd_full_i      (cmd_full_i),
    .dout_full_i     (dout_full_i),
    .cin_empty_i     (cin_empty_i),
    .cin_tag_i       (cin_rdata_i[TAG_W-1:0]),
    .din_empty_i     (din_empty_i),
    .cmd_wr_en_o     (cmd_wr_en_o),
    .csel_o          (csel),
    .dout_wr_en_o    (dout_wr_en_o),
    .cin_rd_en_o     (cin_rd_en_o),
    .din_rd_en_o     (din_rd_en_o),
    .restore_we_o    (restore_we),
    .idx_o           (idx),
    .init_set_o      (init_flag_set_o),
    .app_word_valid_o(app_word_valid_o),
    .running_o       (running_o),
    .parked_o        (parked_o)
  );

  rcfg_cmd_fmt #(
    .RANK_W   (RANK_W),
    .LEN_W    (LEN_W),
    .TAG_W    (TAG_W),
    .HOST_RANK(HOST_RANK),
    .CTX_WORDS(CTX_WORDS),
    .TAG_CFG  (TAG_CFG),
    .TAG_DONE (TAG_DONE)
  ) i_fmt (
    .csel_i(csel),
    .cmd_o (cmd_wdata_o)
  );

  assign app_we = ctx_wr_en_i && running_o;

  rcfg_ctx_store #(
    .DATA_W   (DATA_W),
    .CTX_WORDS(CTX_WORDS),
    .IDX_W    (IDX_W)
  ) i_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .app_we_i   (app_we),
    .app_widx_i (ctx_wr_idx_i),
    .app_wdata_i(ctx_wr_data_i),
    .rest_we_i  (restore_we),
    .rest_idx_i (idx),
    .rest_data_i(din_rdata_i),
    .app_ridx_i (ctx_rd_idx_i),
    .app_rdata_o(ctx_rd_data_o),
    .snd_idx_i  (idx),
    .snd_data_o (dout_wdata_o)
  );

  assign app_word_o = cin_rdata_i;

  // Handshake events brought out for the checks below
  logic       cmd_fire, dout_fire, din_fire;
  logic [1:0] cmd_op;
  assign cmd_fire  = cmd_wr_en_o && !cmd_full_i;
  assign dout_fire = dout_wr_en_o && !dout_full_i;
  assign din_fire  = din_rd_en_o && !din_empty_i;
  assign cmd_op    = cmd_wdata_o[CMD_W-1 -: 2];

  logic [IDX_W:0] pay_cnt_q;
  logic [IDX_W:0] rest_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_cnt_q  <= '0;
      rest_cnt_q <= '0;
    end else begin
      if (cmd_fire && cmd_op == OP_SEND) pay_cnt_q <= '0;
      else if (dout_fire)                pay_cnt_q <= pay_cnt_q + (IDX_W+1)'(1);
      if (din_fire)                      rest_cnt_q <= rest_cnt_q + (IDX_W+1)'(1);
    end
  end

  // R2: FIFO discipline at the engine boundary
  a_r2_fifo_rules: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en_o |-> !cmd_full_i) and (dout_wr_en_o |-> !dout_full_i) and
    (cin_rd_en_o |-> !cin_empty_i) and (din_rd_en_o |-> !din_empty_i));

  // R3: the flag request coincides with a formatted init command
  a_r3_init_word: assert property (@(posedge clk) disable iff (!rst_n)
    init_flag_set_o |-> (cmd_wr_en_o && cmd_op == OP_INIT));

  // R7: the receive post follows a complete payload
  a_r7_post_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == OP_RECV) |-> (pay_cnt_q == (IDX_W+1)'(CTX_WORDS)));

  // R4: running starts with either no restore or a complete one
  a_r4_restore_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> (rest_cnt_q == '0 || rest_cnt_q == (IDX_W+1)'(CTX_WORDS)));

endmodule

// File: tb/test_rcfg_handshake_ctrl.sv
module test_rcfg_handshake_ctrl;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int CW = 30;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          flag_q;
  logic          init_set;
  logic          pr_req;
  logic          cmd_we;  logic [CW-1:0] cmd_wd;  logic cmd_full;
  logic          dout_we; logic [DW-1:0] dout_wd; logic dout_full;
  logic          cin_re;  logic [CW-1:0] cin_rd;  logic cin_empty;
  logic          din_re;  logic [DW-1:0] din_rd;  logic din_empty;
  logic          ctx_we;  logic [IW-1:0] ctx_widx; logic [DW-1:0] ctx_wd;
  logic [IW-1:0] ctx_ridx; logic [DW-1:0] ctx_rd;
  logic          app_v;   logic [CW-1:0] app_w;
  logic          running, parked;

  rcfg_handshake_ctrl i_rcfg_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .init_flag_i(flag_q), .init_flag_set_o(init_set),
    .pr_request_i(pr_req),
    .cmd_wr_en_o(cmd_we), .cmd_wdata_o(cmd_wd), .cmd_full_i(cmd_full),
    .dout_wr_en_o(dout_we), .dout_wdata_o(dout_wd), .dout_full_i(dout_full),
    .cin_rd_en_o(cin_re), .cin_rdata_i(cin_rd), .cin_empty_i(cin_empty),
    .din_rd_en_o(din_re), .din_rdata_i(din_rd), .din_empty_i(din_empty),
    .ctx_wr_en_i(ctx_we), .ctx_wr_idx_i(ctx_widx), .ctx_wr_data_i(ctx_wd),
    .ctx_rd_idx_i(ctx_ridx), .ctx_rd_data_o(ctx_rd),
    .app_word_valid_o(app_v), .app_word_o(app_w),
    .running_o(running), .parked_o(parked)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int init_pulses = 0;
  string cur_req = "R1";
  logic stall_en = 1'b0;

  logic [32:0]   exp_q[$];     // {is_payload, value}
  logic [CW-1:0] app_exp_q[$];
  logic [CW-1:0] cin_q[$];
  logic [DW-1:0] din_q[$];
  logic [DW-1:0] model_ctx [NW];
  logic s_cr, s_dr, s_is;

  function automatic logic [CW-1:0] mk(int op, int rank, int len, int tag);
    return CW'((op * 32'h1000_0000) + (rank * 32'h0010_0000) + (len * 256) + tag);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic score(logic kind, logic [31:0] v);
    logic [32:0] e;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL %s actual=unexpected %0h expected=no output", cur_req, {kind, v});
    end else begin
      e = exp_q.pop_front();
      chk(cur_req, {31'd0, kind, v}, {31'd0, e});
    end
  endtask

  // Engine model and monitor: sample before the edge, update after it
  initial begin
    cmd_full = 0; dout_full = 0; cin_empty = 1; din_empty = 1;
    cin_rd = '0; din_rd = '0; s_cr = 0; s_dr = 0; s_is = 0;
    forever begin
      @(negedge clk); #8;
      s_cr = 0; s_dr = 0; s_is = 0;
      if (rst_n) begin
        if (cmd_we)  chk("R2 cmd write while full", {63'd0, cmd_full}, 64'd0);
        if (dout_we) chk("R2 data write while full", {63'd0, dout_full}, 64'd0);
        if (cin_re)  chk("R2 control read while empty", {63'd0, cin_empty}, 64'd0);
        if (din_re)  chk("R2 data read while empty", {63'd0, din_empty}, 64'd0);
        if (cmd_we && !cmd_full)   score(1'b0, {2'b00, cmd_wd});
        if (dout_we && !dout_full) score(1'b1, dout_wd);
        if (app_v) begin
          if (app_exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 actual=unexpected app word %0h expected=none", app_w);
          end else chk("R9 app word", {34'd0, app_w}, {34'd0, app_exp_q.pop_front()});
        end
        if (init_set) init_pulses++;
        s_cr = cin_re && !cin_empty;
        s_dr = din_re && !din_empty;
        s_is = init_set;
      end
      @(posedge clk); #1;
      cyc++;
      if (s_cr && cin_q.size() > 0) void'(cin_q.pop_front());
      if (s_dr && din_q.size() > 0) void'(din_q.pop_front());
      if (s_is) flag_q = 1'b1;
      cmd_full  = stall_en && (cyc % 3 == 0);
      dout_full = stall_en && (cyc % 2 == 1);
      cin_empty = (cin_q.size() == 0);
      cin_rd    = cin_empty ? '0 : cin_q[0];
      din_empty = (din_q.size() == 0) || (stall_en && (cyc % 4 == 1));
      din_rd    = (din_q.size() == 0) ? '0 : din_q[0];
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic drain(string req);
    int n = 0;
    while ((exp_q.size() != 0 || app_exp_q.size() != 0) && n < 2000) begin
      tick(1); n++;
    end
    tick(2);
    chk(req, exp_q.size() + app_exp_q.size(), 0);
  endtask

  task automatic wait_running();
    int n = 0;
    while (!running && n < 500) begin tick(1); n++; end
  endtask

  task automatic ctx_write(int idx, logic [DW-1:0] d);
    tick(1);
    ctx_we = 1; ctx_widx = IW'(idx); ctx_wd = d;
    tick(1);
    ctx_we = 0;
  endtask

  task automatic ctx_check(string req);
    for (int i = 0; i < NW; i++) begin
      ctx_ridx = IW'(i); #1;
      chk(req, {32'd0, ctx_rd}, {32'd0, model_ctx[i]});
    end
  endtask

  task automatic do_reset();
    tick(1);
    rst_n = 0;
    exp_q.delete(); app_exp_q.delete(); cin_q.delete(); din_q.delete();
    #1;
    chk("R1 strobes in reset", {58'd0, cmd_we, dout_we, cin_re, din_re, init_set, app_v}, 64'd0);
    chk("R1 status in reset", {62'd0, running, parked}, 64'd0);
    tick(3);
    rst_n = 1;
  endtask

  task automatic expect_send(logic [CW-1:0] head);
    exp_q.push_back({1'b0, 2'b00, head});
    for (int i = 0; i < NW; i++) exp_q.push_back({1'b1, model_ctx[i]});
    exp_q.push_back({1'b0, 2'b00, mk(2, 0, NW, 8'hF1)});
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; flag_q = 0; pr_req = 0; ctx_we = 0; ctx_widx = '0; ctx_wd = '0; ctx_ridx = '0;
    for (int i = 0; i < NW; i++) model_ctx[i] = '0;
    #5;
    chk("R1 strobes at start", {58'd0, cmd_we, dout_we, cin_re, din_re, init_set, app_v}, 64'd0);
    chk("R1 status at start", {62'd0, running, parked}, 64'd0);
    ctx_check("R1 context cleared");
    tick(3);
    rst_n = 1;

    // First boot: flag clear
    cur_req = "R3";
    exp_q.push_back({1'b0, 2'b00, mk(3, 0, 0, 0)});
    wait_running();
    drain("R3 init command");
    chk("R3 running", {63'd0, running}, 64'd1);
    chk("R3 flag set", {63'd0, flag_q}, 64'd1);
    chk("R3 one flag pulse", init_pulses, 1);

    // Context load while running
    for (int i = 0; i < NW; i++) begin
      model_ctx[i] = 32'hA5A5_0000 + 32'h1111 * i;
      ctx_write(i, model_ctx[i]);
    end
    ctx_check("R5 context write");

    // Application word pass-through
    cur_req = "R9";
    app_exp_q.push_back(mk(1, 3, 2, 8'h22));
    cin_q.push_back(mk(1, 3, 2, 8'h22));
    drain("R9 app word delivered");
    chk("R9 still running", {63'd0, running}, 64'd1);

    // Host-initiated configure
    cur_req = "R6";
    expect_send(mk(1, 0, NW, 8'hF0));
    cin_q.push_back(mk(1, 0, 0, 8'hF0));
    drain("R6 consent and payload");
    chk("R7 parked", {62'd0, running, parked}, 64'd1);

    // Parked block ignores everything
    cur_req = "R7";
    cin_q.push_back(mk(1, 3, 1, 8'h22));
    pr_req = 1;
    tick(20);
    pr_req = 0;
    chk("R7 arrival left in FIFO", cin_q.size(), 1);
    chk("R7 still parked", {63'd0, parked}, 64'd1);
    ctx_write(1, 32'hDEAD_BEEF);
    ctx_check("R5 write ignored when parked");

    // Successor wake-up with flag set, under stalls
    do_reset();
    cur_req = "R4";
    stall_en = 1;
    cin_q.push_back(mk(1, 0, 1, 8'h33));
    cin_q.push_back(mk(1, 0, NW, 8'hF1));
    tick(12);
    chk("R4 control words consumed", cin_q.size(), 0);
    chk("R4 waits for payload", {63'd0, running}, 64'd0);
    for (int i = 0; i < NW; i++) begin
      model_ctx[i] = 32'hC0DE_0000 + i;
      din_q.push_back(model_ctx[i]);
    end
    wait_running();
    chk("R4 running after restore", {63'd0, running}, 64'd1);
    chk("R4 no second init", init_pulses, 1);
    ctx_check("R4 restored context order");

    // Module-initiated swap with back-pressure
    cur_req = "R10";
    expect_send(mk(1, 0, NW, 8'hF1));
    pr_req = 1;
    tick(1);
    pr_req = 0;
    drain("R10 request under stalls");
    chk("R8 parked after request", {62'd0, running, parked}, 64'd1);
    stall_en = 0;

    // Arrival beats a simultaneous request
    do_reset();
    cin_q.push_back(mk(1, 0, NW, 8'hF1));
    for (int i = 0; i < NW; i++) begin
      model_ctx[i] = 32'h5EED_0000 + 32'h10 * i;
      din_q.push_back(model_ctx[i]);
    end
    wait_running();
    cur_req = "R8";
    expect_send(mk(1, 0, NW, 8'hF0));
    cin_q.push_back(mk(1, 0, 0, 8'hF0));
    tick(1);
    pr_req = 1;
    tick(1);
    pr_req = 0;
    drain("R8 arrival has precedence");
    chk("R8 parked", {63'd0, parked}, 64'd1);
    chk("R4 no init after restore", init_pulses, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule